// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Character Queue

This block receives start-stop serial characters on a single input line. An external divider supplies a one-cycle enable sixteen times per bit period. The receiver synchronises the line, finds the start bit and samples each later bit at its centre. It then writes the character into a 16-entry queue together with that character's own parity-error and framing-error flags. The frame layout is chosen at run time: 7 or 8 data bits, no parity or even or odd parity, and one or two stop bits. That gives eight formats.

A consumer pops characters through a first-word-fall-through read port and sees the queue's empty state and fill count. Two sticky outputs report conditions that belong to no single stored character. Overrun means a character arrived while the queue was full. Break means the line stayed at the space level for a further whole frame after a framing error. Each sticky output has its own clear input. The synchronised line level is available as an output, so the line can be inspected after a framing error.

Top module: `serial_rx_queue`

## Requirements
- R1: After a synchronous reset the queue is empty (`fifoEmpty`=1, `fifoCount`=0), `overrunFlag` and `breakFlag` are 0, and `lineLevel` is 1.
- R2: With 8 data bits and no parity, a frame is stored as one queue entry. A frame is a low start bit, data bits least significant first, and a high stop bit, each lasting 16 asserted `tickEn` cycles. The entry has both error flags 0. This holds whatever the spacing of `tickEn` pulses.
- R3: With `cfgSevenBit`=1, seven data bits are taken and bit 7 of the stored word is 0.
- R4: With `cfgParEn`=1, one parity bit follows the data. `cfgParOdd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets the entry's `popParErr`. With `cfgParEn`=0 the bit after the data is taken as the stop bit.
- R5: A stop bit sampled low stores the character with `popFrmErr`=1.
- R6: With `cfgTwoStop`=1 only the first stop bit is checked. A short low pulse during the second stop bit adds no entry and sets no error flag.
- R7: A start bit that is high again at its centre sample is discarded, and no entry is written.
- R8: The queue holds up to 16 entries and returns them in arrival order. `popData`/`popParErr`/`popFrmErr` show the oldest entry. A cycle with `popEn`=1 while not empty removes it. `fifoCount` gives the number held.
- R9: A character completed while 16 entries are held sets `overrunFlag`. That character is dropped and the stored entries are unchanged.
- R10: `breakFlag` is set when a frame with a framing error is followed directly by a frame whose data, parity and stop samples are all low. A single framing-error frame followed by a high line does not set it.
- R11: `overrunFlag` and `breakFlag` stay set until `overrunClr` or `breakClr` respectively is held high for a cycle.
- R12: `lineLevel` follows `rxLine` two clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Oversampling enable, 16 per bit period |
| rxLine | input | 1 | Serial input line, idle high |
| cfgSevenBit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfgParEn | input | 1 | 1 expects a parity bit |
| cfgParOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| popEn | input | 1 | Remove the oldest queue entry |
| overrunClr | input | 1 | Clear the overrun flag |
| breakClr | input | 1 | Clear the break flag |
| popData | output | 8 | Oldest entry's data |
| popParErr | output | 1 | Oldest entry's parity error |
| popFrmErr | output | 1 | Oldest entry's framing error |
| fifoEmpty | output | 1 | Queue is empty |
| fifoCount | output | 5 | Entries held |
| overrunFlag | output | 1 | Sticky overrun indication |
| breakFlag | output | 1 | Sticky break indication |
| lineLevel | output | 1 | Synchronised line level |

## Verification
The properties checked on every cycle cover the queue and the sticky flags. The count never passes 16 and never falls without a pop. A full queue with no pop stays full. Overrun rises only when the queue was full, and both flags hold until cleared. The frame-level behaviours can only be shown by the bench's serial scenarios, because each depends on a whole sequence of line levels: bit order and centre sampling, 7-bit masking, the parity sense, framing errors, glitch rejection, the second stop bit being ignored, the dropped seventeenth character and the two-frame break rule.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       clrShift;   // new frame starts: clear assembly register
    logic       capData;    // centre of a data bit
    logic [2:0] bitIdx;     // data bit position being captured
    logic       capPar;     // centre of the parity bit
    logic       commit;     // centre of the first stop bit: store character
  } rxStrobe_t;

  typedef struct packed {
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
  } rxEntry_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       lineSync,
  input  logic       cfgSevenBit,
  input  logic       cfgParEn,
  input  logic       cfgTwoStop,
  output rxStrobe_t  strobe
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] MID  = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rxState_t;

  rxState_t      state;
  logic [PW-1:0] phase;
  logic [2:0]    bitIdx;
  logic [2:0]    lastIdx;
  logic          midTick;
  logic          endTick;

  assign lastIdx = cfgSevenBit ? 3'd6 : 3'd7;
  assign midTick = tickEn && (phase == MID);
  assign endTick = tickEn && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tickEn) begin
      if (state == S_IDLE) begin
        if (!lineSync) begin
          state <= S_START;
          phase <= PW'(1);  // the detecting tick counts as the first
        end
      end else begin
        phase <= phase + 1'b1;
        unique case (state)
          S_START: begin
            if (midTick && lineSync) state <= S_IDLE;  // glitch
            else if (endTick) begin
              state  <= S_DATA;
              bitIdx <= '0;
            end
          end
          S_DATA: begin
            if (endTick) begin
              if (bitIdx == lastIdx) state <= cfgParEn ? S_PAR : S_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end
          end
          S_PAR: if (endTick) state <= S_STOP;
          S_STOP: begin
            // good single stop: hunt from mid-bit; otherwise finish the bit
            if (midTick && lineSync && !cfgTwoStop) state <= S_IDLE;
            else if (endTick) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clrShift = tickEn && (state == S_IDLE) && !lineSync;
    strobe.capData  = midTick && (state == S_DATA);
    strobe.bitIdx   = bitIdx;
    strobe.capPar   = midTick && (state == S_PAR);
    strobe.commit   = midTick && (state == S_STOP);
  end
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rxLine,
  input  rxStrobe_t                    strobe,
  input  logic                         cfgSevenBit,
  input  logic                         cfgParEn,
  input  logic                         cfgParOdd,
  input  logic                         popEn,
  input  logic                         overrunClr,
  input  logic                         breakClr,
  output logic                         lineSync,
  output logic [7:0]                   popData,
  output logic                         popParErr,
  output logic                         popFrmErr,
  output logic                         fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output logic                         overrunFlag,
  output logic                         breakFlag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          sync1, sync2;
  logic [7:0]    shReg;
  logic          parBit;
  logic [7:0]    dataWord;
  logic          parErr, frmErr, allLow;
  logic          prevFerr;
  rxEntry_t      mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, doPush, doPop;
  rxEntry_t      head;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // two-flop synchroniser, idle level high
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxLine;
      sync2 <= sync1;
    end
  end
  assign lineSync = sync2;

  always_ff @(posedge clk) begin
    if (rst || strobe.clrShift) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (strobe.capData) shReg[strobe.bitIdx] <= sync2;
      if (strobe.capPar)  parBit <= sync2;
    end
  end

  assign dataWord = cfgSevenBit ? {1'b0, shReg[6:0]} : shReg;
  assign parErr   = cfgParEn && ((^dataWord ^ parBit) != cfgParOdd);
  assign frmErr   = !sync2;
  assign allLow   = (dataWord == 8'd0) && !parBit && frmErr;

  assign full   = (count == CW'(DEPTH));
  assign doPush = strobe.commit && !full;
  assign doPop  = popEn && (count != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= '{data: dataWord, parErr: parErr, frmErr: frmErr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // sticky conditions: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      overrunFlag <= 1'b0;
      breakFlag   <= 1'b0;
      prevFerr    <= 1'b0;
    end else begin
      if (strobe.commit && full) overrunFlag <= 1'b1;
      else if (overrunClr)       overrunFlag <= 1'b0;
      if (strobe.commit && prevFerr && allLow) breakFlag <= 1'b1;
      else if (breakClr)                       breakFlag <= 1'b0;
      if (strobe.commit) prevFerr <= frmErr;
    end
  end

  assign head      = mem[rdPtr];
  assign popData   = head.data;
  assign popParErr = head.parErr;
  assign popFrmErr = head.frmErr;
  assign fifoEmpty = (count == '0);
  assign fifoCount = count;
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tickEn,
  input  logic                       rxLine,
  input  logic                       cfgSevenBit,
  input  logic                       cfgParEn,
  input  logic                       cfgParOdd,
  input  logic                       cfgTwoStop,
  input  logic                       popEn,
  input  logic                       overrunClr,
  input  logic                       breakClr,
  output logic [7:0]                 popData,
  output logic                       popParErr,
  output logic                       popFrmErr,
  output logic                       fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic                       overrunFlag,
  output logic                       breakFlag,
  output logic                       lineLevel
);
  rxStrobe_t strobe;
  logic      lineSync;

  rxq_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .lineSync(lineSync),
    .cfgSevenBit(cfgSevenBit), .cfgParEn(cfgParEn), .cfgTwoStop(cfgTwoStop),
    .strobe(strobe)
  );

  rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .rxLine(rxLine), .strobe(strobe),
    .cfgSevenBit(cfgSevenBit), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .popEn(popEn), .overrunClr(overrunClr), .breakClr(breakClr),
    .lineSync(lineSync), .popData(popData), .popParErr(popParErr),
    .popFrmErr(popFrmErr), .fifoEmpty(fifoEmpty), .fifoCount(fifoCount),
    .overrunFlag(overrunFlag), .breakFlag(breakFlag)
  );

  assign lineLevel = lineSync;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       popEn,
  input logic                       overrunClr,
  input logic                       breakClr,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic                       overrunFlag,
  input logic                       breakFlag
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= CW'(DEPTH));

  a_r8_no_loss_without_pop: assert property (@(posedge clk) disable iff (rst)
    !popEn |=> fifoCount >= $past(fifoCount));

  a_r9_full_stays_full: assert property (@(posedge clk) disable iff (rst)
    (fifoCount == CW'(DEPTH) && !popEn) |=> fifoCount == CW'(DEPTH));

  a_r9_overrun_only_when_full: assert property (@(posedge clk) disable iff (rst)
    $rose(overrunFlag) |-> $past(fifoCount) == CW'(DEPTH));

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrunFlag && !overrunClr) |=> overrunFlag);

  a_r11_break_sticky: assert property (@(posedge clk) disable iff (rst)
    (breakFlag && !breakClr) |=> breakFlag);
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .popEn(popEn), .overrunClr(overrunClr),
  .breakClr(breakClr), .fifoCount(fifoCount), .overrunFlag(overrunFlag),
  .breakFlag(breakFlag)
);

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
  localparam int OSR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic rxLine = 1'b1;
  logic cfgSevenBit = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgTwoStop = 1'b0;
  logic popEn = 1'b0, overrunClr = 1'b0, breakClr = 1'b0;
  logic [7:0] popData;
  logic popParErr, popFrmErr, fifoEmpty, overrunFlag, breakFlag, lineLevel;
  logic [4:0] fifoCount;

  int nChk = 0, nBad = 0;
  int tickDiv = 1, tcnt = 0;

  logic [7:0] qd [16];
  bit         qp [16];
  bit         qf [16];

  serial_rx_queue u_serial_rx_queue (
    .clk(clk), .rst(rst), .tickEn(tickEn), .rxLine(rxLine),
    .cfgSevenBit(cfgSevenBit), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgTwoStop(cfgTwoStop), .popEn(popEn), .overrunClr(overrunClr),
    .breakClr(breakClr), .popData(popData), .popParErr(popParErr),
    .popFrmErr(popFrmErr), .fifoEmpty(fifoEmpty), .fifoCount(fifoCount),
    .overrunFlag(overrunFlag), .breakFlag(breakFlag), .lineLevel(lineLevel)
  );

  always #2 clk = ~clk;  // 250 MHz

  always @(negedge clk) begin
    if (tcnt + 1 >= tickDiv) begin
      tickEn <= 1'b1;
      tcnt   <= 0;
    end else begin
      tickEn <= 1'b0;
      tcnt   <= tcnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskWord(input logic [7:0] d, input bit seven);
    return seven ? {1'b0, d[6:0]} : d;
  endfunction

  function automatic bit parityBit(input logic [7:0] m, input bit odd, input bit corrupt);
    return (^m) ^ odd ^ corrupt;
  endfunction

  // counts ticks that were present at the preceding rising edge
  task automatic holdTicks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (tickEn) k++;
    end
  endtask

  task automatic sendBit(input bit level);
    rxLine = level;
    holdTicks(OSR);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit badStop);
    logic [7:0] m;
    m = maskWord(d, cfgSevenBit);
    sendBit(1'b0);
    for (int i = 0; i < (cfgSevenBit ? 7 : 8); i++) sendBit(m[i]);
    if (cfgParEn) sendBit(parityBit(m, cfgParOdd, badPar));
    sendBit(!badStop);
    if (cfgTwoStop) sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic popCheck(input logic [7:0] d, input bit pe, input bit fe, input string tag);
    chk({tag, " not empty"}, fifoEmpty, 0);
    chk({tag, " data"}, popData, d);
    chk({tag, " parErr"}, popParErr, pe);
    chk({tag, " frmErr"}, popFrmErr, fe);
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic setCfg(input bit seven, input bit par, input bit odd, input bit two);
    cfgSevenBit = seven; cfgParEn = par; cfgParOdd = odd; cfgTwoStop = two;
  endtask

  task automatic drain();
    while (!fifoEmpty) begin
      popEn = 1'b1;
      @(negedge clk);
    end
    popEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd77213));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 count", fifoCount, 0);
    chk("R1 overrun", overrunFlag, 0);
    chk("R1 break", breakFlag, 0);
    chk("R1 lineLevel", lineLevel, 1);

    // R12 line level delay, also a 2-cycle low is a start glitch (R7)
    rxLine = 1'b0;
    @(negedge clk);
    chk("R12 level after 1 clk", lineLevel, 1);
    @(negedge clk);
    chk("R12 level after 2 clk", lineLevel, 0);
    rxLine = 1'b1;
    holdTicks(40);
    chk("R7 short glitch no entry", fifoCount, 0);

    // R7 low for 5 ticks, high before centre
    rxLine = 1'b0; holdTicks(5); rxLine = 1'b1; holdTicks(40);
    chk("R7 start glitch no entry", fifoCount, 0);

    // R2 8N1, two patterns
    setCfg(0, 0, 0, 0);
    sendFrame(8'hA5, 0, 0);
    sendFrame(8'h3C, 0, 0);
    chk("R8 count two", fifoCount, 2);
    popCheck(8'hA5, 0, 0, "R2 first");
    popCheck(8'h3C, 0, 0, "R2 second");
    chk("R8 empty after pops", fifoEmpty, 1);

    // R2 with slow tick
    tickDiv = 3;
    sendFrame(8'h81, 0, 0);
    popCheck(8'h81, 0, 0, "R2 slow tick");
    tickDiv = 1;

    // R3 seven bits: bit 7 on the wire is never sent
    setCfg(1, 0, 0, 0);
    sendFrame(8'hFF, 0, 0);
    popCheck(8'h7F, 0, 0, "R3 seven bit");

    // R4 even and odd parity, good and corrupted
    setCfg(0, 1, 0, 0);
    sendFrame(8'h07, 0, 0);
    sendFrame(8'h07, 1, 0);
    setCfg(1, 1, 1, 0);
    sendFrame(8'h55, 0, 0);
    sendFrame(8'h55, 1, 0);
    popCheck(8'h07, 0, 0, "R4 even ok");
    popCheck(8'h07, 1, 0, "R4 even bad");
    popCheck(8'h55, 0, 0, "R4 odd ok");
    popCheck(8'h55, 1, 0, "R4 odd bad");

    // R5 framing error, R10 single framing error is not a break
    setCfg(0, 0, 0, 0);
    sendFrame(8'h81, 0, 1);
    holdTicks(32);
    chk("R10 no break on single ferr", breakFlag, 0);
    popCheck(8'h81, 0, 1, "R5 framing");

    // R6 two stop bits, low pulse in the second stop bit
    setCfg(0, 0, 0, 1);
    rxLine = 1'b0; holdTicks(OSR);
    for (int i = 0; i < 8; i++) begin rxLine = (8'h5A >> i) & 1; holdTicks(OSR); end
    rxLine = 1'b1; holdTicks(OSR + 4);
    rxLine = 1'b0; holdTicks(4);
    rxLine = 1'b1; holdTicks(3 * OSR);
    chk("R6 one entry", fifoCount, 1);
    popCheck(8'h5A, 0, 0, "R6 second stop ignored");

    // R9 overrun with seventeen frames
    setCfg(0, 0, 0, 0);
    for (int i = 0; i < 17; i++) sendFrame(8'(i * 7 + 3), 0, 0);
    chk("R9 count full", fifoCount, 16);
    chk("R9 overrun set", overrunFlag, 1);
    holdTicks(50);
    chk("R11 overrun sticky", overrunFlag, 1);
    for (int i = 0; i < 16; i++) popCheck(8'(i * 7 + 3), 0, 0, "R9 kept entry");
    chk("R9 dropped 17th", fifoEmpty, 1);
    overrunClr = 1'b1; @(negedge clk); overrunClr = 1'b0;
    chk("R11 overrun cleared", overrunFlag, 0);

    // R10 break: line low for 25 bit times
    rxLine = 1'b0; holdTicks(25 * OSR);
    rxLine = 1'b1; holdTicks(12 * OSR);
    chk("R10 break set", breakFlag, 1);
    chk("R10 entries", fifoCount, 3);
    popCheck(8'h00, 0, 1, "R10 first break frame");
    holdTicks(20);
    chk("R11 break sticky", breakFlag, 1);
    breakClr = 1'b1; @(negedge clk); breakClr = 1'b0;
    chk("R11 break cleared", breakFlag, 0);
    drain();

    // random batches, R8 ordering across formats
    for (int b = 0; b < 6; b++) begin
      int n;
      n = 1 + ($urandom % 5);
      setCfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      tickDiv = 1 + ($urandom % 3);
      for (int i = 0; i < n; i++) begin
        logic [7:0] d;
        bit bp, bs;
        d  = 8'($urandom);
        bp = cfgParEn && (($urandom % 4) == 0);
        bs = (($urandom % 5) == 0);
        if (bs) d = d | 8'h01;
        qd[i] = maskWord(d, cfgSevenBit);
        qp[i] = bp;
        qf[i] = bs;
        sendFrame(d, bp, bs);
      end
      chk("R8 random count", fifoCount, n);
      for (int i = 0; i < n; i++) popCheck(qd[i], qp[i], qf[i], "R8 random entry");
    end
    chk("R10 random no break", breakFlag, 0);
    chk("R9 random no overrun", overrunFlag, 0);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule